// File: doc/BRIEF.md
# Three-Wire Radio Register Programming Master

This block drives a three-wire serial link (a frame enable, a serial clock and a bidirectional data line) plus a separate read/write select line. A radio front end's control registers are programmed and read back over this link. A host issues one command at a time through a request/acknowledge handshake. A write command carries a register address and a 12-bit value. A read command carries a register address, and its 12-bit result comes back on a data bus qualified by a single-cycle valid strobe.

Every step of a frame, whether a pin change or a hold, lasts one tick of an internal clock-enable divider. The `HALF_DIV` parameter sets the tick length in system clock cycles, so it sets the half-period of the serial clock. The divider restarts when a command is accepted, so the first step of a frame is as long as every later step.

Write frames pack two data bits into each serial clock period. The first bit is placed while the clock is low and is captured on the rising edge. The second bit is placed while the clock is still high and is captured on the falling edge. Read frames shift out a short address, raise the select line and release the data pin. The master then clocks in the reply one bit per period.

Top module: `rf3w_master`

## Requirements
- R1: During and after reset, with no command in flight, the enable output is high, the serial clock is low, the data pin is driven (`sr_oe` = 1), the select line is low and `busy` is low.
- R2: A write sends a 16-bit frame formed as `{data[11:0], addr[3:0]}` (the address in the low four bits), most significant bit first.
- R3: Before a frame is shifted, enable is held high for one step and then driven low. Enable stays low while bits are shifted and rises after the last bit to latch the frame. A write carries exactly 16 bits while enable is low.
- R4: A write uses 8 serial clock periods. Even-indexed bits (counting from the first bit sent) are stable at a rising clock edge, and odd-indexed bits are stable at a falling clock edge.
- R5: A read shifts exactly 5 address bits (`addr[4:0]`), most significant first, with the same two-bits-per-period placement. The select line rises after the fifth bit, while the clock is still high.
- R6: After the address phase of a read, the master releases the data pin (`sr_oe` = 0) and runs 12 clock periods. It samples `sr_din` at the end of each high phase and assembles the result most significant bit first.
- R7: A read ends with enable and the select line both high and the data pin driven again.
- R8: `req_ack` is high exactly when `req_valid` is high and no frame is in flight. A request made while `busy` is high is not acknowledged and starts no frame.
- R9: `rd_valid` pulses for one cycle with `rd_data` after each read and never after a write.
- R10: Every level of the serial clock lasts at least `HALF_DIV` system clock cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Command request |
| req_write | input | 1 | 1 = write command, 0 = read command |
| req_addr | input | RADDR_W | Register address (writes use the low WADDR_W bits) |
| req_wdata | input | DATA_W | Write value |
| req_ack | output | 1 | Command accepted this cycle |
| busy | output | 1 | Frame in flight |
| rd_valid | output | 1 | One-cycle strobe for read data |
| rd_data | output | DATA_W | Value returned by the last read |
| sr_en | output | 1 | Serial frame enable |
| sr_clk | output | 1 | Serial clock |
| sr_dout | output | 1 | Data pin output value |
| sr_oe | output | 1 | Data pin output enable (0 = released to the radio) |
| sr_din | input | 1 | Data pin input value |
| sr_rw | output | 1 | Read/write select line |

## Verification
The bench builds the block with the default widths (4-bit write address, 5-bit read address, 12-bit data) and `HALF_DIV` = 3. With a divider greater than one, each step spans several system cycles, so the minimum-hold check on the serial clock is meaningful. A divider of 3 still keeps each frame to about a hundred cycles, which leaves room for dozens of random writes and reads plus directed corner cases: all-zero and all-one values, alternating bit patterns, the extreme read addresses, and a request held high while a frame is in flight. A behavioural radio model in the bench decodes the pins by clock edge and answers reads from an address-derived value.

// File: rtl/rf3w_pkg.sv
package rf3w_pkg;

    // Frame steps; each lasts one divider tick
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_PRE,
        PH_LEAD,
        PH_SHIFT,
        PH_RWSET,
        PH_TURN,
        PH_RDATA,
        PH_TAIL
    } phase_e;

    // Pin levels produced by the sequencer
    typedef struct packed {
        logic en;
        logic sck;
        logic dout;
        logic oe;
        logic rw;
    } pins_t;

    localparam pins_t PINS_IDLE = '{en: 1'b1, sck: 1'b0, dout: 1'b0, oe: 1'b1, rw: 1'b0};

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/rf3w_tick.sv
module rf3w_tick #(
    parameter int unsigned HALF_DIV = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    generate
        if (HALF_DIV <= 1) begin : g_direct
            assign tick = run;
        end else begin : g_count
            localparam int unsigned CW = $clog2(HALF_DIV);
            localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);
            logic [CW-1:0] cnt;

            always_ff @(posedge clk) begin
                if (rst || !run) begin
                    cnt <= '0;
                end else if (cnt == LAST) begin
                    cnt <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end

            assign tick = run && (cnt == LAST);
        end
    endgenerate
endmodule

// File: rtl/rf3w_seq.sv
module rf3w_seq
    import rf3w_pkg::*;
#(
    parameter int unsigned WADDR_W = 4,
    parameter int unsigned RADDR_W = 5,
    parameter int unsigned DATA_W  = 12
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               tick,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [RADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0]  req_wdata,
    input  logic               sr_din,
    output logic               busy,
    output logic               req_ack,
    output pins_t              pins,
    output logic               rd_valid,
    output logic [DATA_W-1:0]  rd_data
);
    localparam int unsigned WFRAME_W = WADDR_W + DATA_W;
    localparam int unsigned SR_W     = max2(WFRAME_W, RADDR_W);
    localparam int unsigned CNT_W    = $clog2(max2(SR_W, DATA_W) + 1);

    phase_e             state;
    logic               is_wr;
    logic               half;
    logic [CNT_W-1:0]   bitcnt;
    logic [SR_W-1:0]    shreg;
    logic [DATA_W-1:0]  rdreg;
    logic [SR_W-1:0]    load_val;
    logic [CNT_W-1:0]   last_bit;

    assign busy    = (state != PH_IDLE);
    assign req_ack = req_valid && (state == PH_IDLE);

    always_comb begin
        if (req_write) begin
            load_val = SR_W'({req_wdata, req_addr[WADDR_W-1:0]}) << (SR_W - WFRAME_W);
        end else begin
            load_val = SR_W'(req_addr) << (SR_W - RADDR_W);
        end
        last_bit = is_wr ? CNT_W'(WFRAME_W - 1) : CNT_W'(RADDR_W - 1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= PH_IDLE;
            is_wr    <= 1'b1;
            half     <= 1'b0;
            bitcnt   <= '0;
            shreg    <= '0;
            rdreg    <= '0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= 1'b0;
            case (state)
                PH_IDLE: begin
                    if (req_valid) begin
                        is_wr  <= req_write;
                        half   <= 1'b0;
                        bitcnt <= '0;
                        shreg  <= load_val;
                        state  <= PH_PRE;
                    end
                end
                PH_PRE:  if (tick) state <= PH_LEAD;
                PH_LEAD: if (tick) state <= PH_SHIFT;
                PH_SHIFT: begin
                    if (tick) begin
                        half <= ~half;
                        if (half) begin
                            shreg <= shreg << 1;
                            if (bitcnt == last_bit) begin
                                bitcnt <= '0;
                                state  <= is_wr ? PH_TAIL : PH_RWSET;
                            end else begin
                                bitcnt <= bitcnt + 1'b1;
                            end
                        end
                    end
                end
                PH_RWSET: begin
                    if (tick) begin
                        half <= ~half;
                        if (half) state <= PH_TURN;
                    end
                end
                PH_TURN: if (tick) state <= PH_RDATA;
                PH_RDATA: begin
                    if (tick) begin
                        half <= ~half;
                        if (half) begin
                            rdreg <= {rdreg[DATA_W-2:0], sr_din};
                            if (bitcnt == CNT_W'(DATA_W - 1)) begin
                                bitcnt <= '0;
                                state  <= PH_TAIL;
                            end else begin
                                bitcnt <= bitcnt + 1'b1;
                            end
                        end
                    end
                end
                PH_TAIL: begin
                    if (tick) begin
                        state <= PH_IDLE;
                        if (!is_wr) begin
                            rd_valid <= 1'b1;
                            rd_data  <= rdreg;
                        end
                    end
                end
                default: state <= PH_IDLE;
            endcase
        end
    end

    // Pin levels per step: even bits rise, odd bits fall
    always_comb begin
        pins = PINS_IDLE;
        case (state)
            PH_LEAD: pins.en = 1'b0;
            PH_SHIFT: begin
                pins.en   = 1'b0;
                pins.sck  = half ^ bitcnt[0];
                pins.dout = shreg[SR_W-1];
            end
            PH_RWSET: begin
                pins.en  = 1'b0;
                pins.sck = ~half;
                pins.rw  = 1'b1;
            end
            PH_TURN: begin
                pins.en = 1'b0;
                pins.oe = 1'b0;
                pins.rw = 1'b1;
            end
            PH_RDATA: begin
                pins.en  = 1'b0;
                pins.sck = half;
                pins.oe  = 1'b0;
                pins.rw  = 1'b1;
            end
            PH_TAIL: pins.rw = ~is_wr;
            default: pins = PINS_IDLE;
        endcase
    end
endmodule

// File: rtl/rf3w_master.sv
module rf3w_master
    import rf3w_pkg::*;
#(
    parameter int unsigned WADDR_W  = 4,
    parameter int unsigned RADDR_W  = 5,
    parameter int unsigned DATA_W   = 12,
    parameter int unsigned HALF_DIV = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [RADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0]  req_wdata,
    output logic               req_ack,
    output logic               busy,
    output logic               rd_valid,
    output logic [DATA_W-1:0]  rd_data,
    output logic               sr_en,
    output logic               sr_clk,
    output logic               sr_dout,
    output logic               sr_oe,
    input  logic               sr_din,
    output logic               sr_rw
);
    logic  tick;
    pins_t pins;

    rf3w_tick #(.HALF_DIV(HALF_DIV)) tick_i (
        .clk  (clk),
        .rst  (rst),
        .run  (busy),
        .tick (tick)
    );

    rf3w_seq #(
        .WADDR_W (WADDR_W),
        .RADDR_W (RADDR_W),
        .DATA_W  (DATA_W)
    ) seq_i (
        .clk       (clk),
        .rst       (rst),
        .tick      (tick),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .sr_din    (sr_din),
        .busy      (busy),
        .req_ack   (req_ack),
        .pins      (pins),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data)
    );

    assign sr_en   = pins.en;
    assign sr_clk  = pins.sck;
    assign sr_dout = pins.dout;
    assign sr_oe   = pins.oe;
    assign sr_rw   = pins.rw;
endmodule

// File: rtl/rf3w_master_chk.sv
module rf3w_master_chk #(
    parameter int unsigned HALF_DIV = 4
) (
    input logic clk,
    input logic rst,
    input logic req_valid,
    input logic req_ack,
    input logic busy,
    input logic rd_valid,
    input logic sr_en,
    input logic sr_clk,
    input logic sr_oe,
    input logic sr_rw
);
    logic        clk_q;
    logic        armed;
    int unsigned hold;

    always_ff @(posedge clk) begin
        if (rst) begin
            clk_q <= 1'b0;
            armed <= 1'b0;
            hold  <= 0;
        end else begin
            clk_q <= sr_clk;
            if (sr_clk != clk_q) begin
                hold  <= 0;
                armed <= 1'b1;
            end else if (hold < HALF_DIV) begin
                hold <= hold + 1;
            end
        end
    end

    // R1
    idle_pins_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (sr_en && !sr_clk && sr_oe && !sr_rw));

    // R8
    ack_free_chk: assert property (@(posedge clk) disable iff (rst)
        req_ack |-> !busy);

    // R8
    ack_given_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !busy) |-> req_ack);

    // R9
    rd_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> !rd_valid);

    // R6
    release_chk: assert property (@(posedge clk) disable iff (rst)
        !sr_oe |-> (sr_rw && !sr_en && busy));

    // R10
    clk_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (armed && (sr_clk != clk_q)) |-> (hold >= HALF_DIV - 1));
endmodule

bind rf3w_master rf3w_master_chk #(.HALF_DIV(HALF_DIV)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ack   (req_ack),
    .busy      (busy),
    .rd_valid  (rd_valid),
    .sr_en     (sr_en),
    .sr_clk    (sr_clk),
    .sr_oe     (sr_oe),
    .sr_rw     (sr_rw)
);

// File: tb/rf3w_master_tb_top.sv
`timescale 1ns/1ps
module rf3w_master_tb_top;
    localparam int HD = 3;
    localparam int WA = 4;
    localparam int RA = 5;
    localparam int DW = 12;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [RA-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          req_ack, busy, rd_valid;
    logic [DW-1:0] rd_data;
    logic          sr_en, sr_clk, sr_dout, sr_oe, sr_rw;
    logic          sr_din = 1'b0;

    always #2.5 clk = ~clk;

    rf3w_master #(.WADDR_W(WA), .RADDR_W(RA), .DATA_W(DW), .HALF_DIV(HD)) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ack(req_ack), .busy(busy),
        .rd_valid(rd_valid), .rd_data(rd_data), .sr_en(sr_en), .sr_clk(sr_clk),
        .sr_dout(sr_dout), .sr_oe(sr_oe), .sr_din(sr_din), .sr_rw(sr_rw)
    );

    int checks = 0;
    int errors = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [11:0] reg_val(input logic [4:0] a);
        return 12'(({7'd0, a} * 12'd149) ^ 12'h5A3);
    endfunction

    // Radio model state
    logic        p_en = 1'b1, p_clk = 1'b0, p_rw = 1'b0;
    logic [15:0] sh = '0;
    int          nb = 0, rises = 0, rd_rises = 0, rk = 0, en_falls = 0;
    logic        rd_mode = 1'b0, seen_rise = 1'b0;
    logic [11:0] mval = '0;
    logic        wr_done = 1'b0, rd_done = 1'b0;
    logic [15:0] got_wframe = '0;
    int          got_wbits = 0, got_rises = 0, got_rbits = 0, got_rdrises = 0;
    logic [4:0]  got_raddr = '0;
    logic        rw_clk_high = 1'b0, tail_rw = 1'b0, tail_oe = 1'b0;
    int          hold = 0, min_hold = 1000;

    always @(posedge clk) begin
        #1;
        if (!rst) begin
            if (p_en && !sr_en) begin
                nb = 0; sh = '0; rises = 0; rd_rises = 0; en_falls++;
            end
            if (!sr_en && !sr_rw && !rd_mode && (sr_clk != p_clk)) begin
                sh = {sh[14:0], sr_dout};
                nb++;
                if (sr_clk) rises++;
            end
            if (!sr_en && sr_rw && !p_rw) begin
                got_raddr = sh[4:0]; got_rbits = nb; rw_clk_high = sr_clk;
                rd_mode = 1'b1; rk = 0; seen_rise = 1'b0;
                mval = reg_val(sh[4:0]);
                sr_din = mval[11];
            end else if (rd_mode && !sr_en) begin
                if (sr_clk && !p_clk) begin
                    seen_rise = 1'b1;
                    if (!sr_oe) rd_rises++;
                end
                if (!sr_clk && p_clk && seen_rise) begin
                    rk++; seen_rise = 1'b0;
                    sr_din = (rk < 12) ? mval[11-rk] : 1'b0;
                end
            end
            if (!p_en && sr_en) begin
                if (!rd_mode) begin
                    wr_done = 1'b1; got_wframe = sh; got_wbits = nb; got_rises = rises;
                end else begin
                    rd_done = 1'b1; tail_rw = sr_rw; tail_oe = sr_oe;
                    got_rdrises = rd_rises; rd_mode = 1'b0;
                end
            end
            if (sr_clk != p_clk) begin
                if (hold < min_hold) min_hold = hold;
                hold = 1;
            end else begin
                hold++;
            end
            p_en = sr_en; p_clk = sr_clk; p_rw = sr_rw;
        end
    end

    int rv_cnt = 0;
    always @(negedge clk) if (!rst && rd_valid) rv_cnt++;

    task automatic do_op(input bit wr, input logic [4:0] a, input logic [11:0] d);
        int rv0;
        @(negedge clk);
        while (busy) @(negedge clk);
        wr_done = 1'b0; rd_done = 1'b0; rv0 = rv_cnt;
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        #0.5;
        check(req_ack == 1'b1, "R8 ack when idle", int'(req_ack), 1);
        @(negedge clk);
        req_valid = 1'b0;
        while (!(wr ? wr_done : rd_done)) @(negedge clk);
        if (wr) begin
            check(got_wframe == {d, a[3:0]}, "R2 write frame", int'(got_wframe), int'({d, a[3:0]}));
            check(got_wbits == 16, "R3 bits while enable low", got_wbits, 16);
            check(got_rises == 8, "R4 clock periods per write", got_rises, 8);
            repeat (4 * HD + 4) @(negedge clk);
            check(rv_cnt == rv0, "R9 no strobe after write", rv_cnt - rv0, 0);
        end else begin
            int n = 0;
            check(got_raddr == a, "R5 read address", int'(got_raddr), int'(a));
            check(got_rbits == 5 && rw_clk_high, "R5 select after fifth bit", got_rbits, 5);
            check(got_rdrises == 12, "R6 released read periods", got_rdrises, 12);
            check(tail_rw && tail_oe, "R7 read tail pins", int'({tail_rw, tail_oe}), 3);
            while (!rd_valid && n < 4 * HD + 4) begin
                @(negedge clk);
                n++;
            end
            check(rd_valid == 1'b1, "R9 read strobe", int'(rd_valid), 1);
            check(rd_data == reg_val(a), "R6 read data", int'(rd_data), int'(reg_val(a)));
            @(negedge clk);
            check(rd_valid == 1'b0, "R9 strobe one cycle", int'(rd_valid), 0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int ef0;
        void'($urandom(32'h5eed1234));
        repeat (3) @(negedge clk);
        check(sr_en && !sr_clk && sr_oe && !sr_rw && !busy, "R1 pins in reset",
              int'({sr_en, sr_clk, sr_oe, sr_rw, busy}), 5'b10100);
        @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        check(sr_en && !sr_clk && sr_oe && !sr_rw && !busy, "R1 pins after reset",
              int'({sr_en, sr_clk, sr_oe, sr_rw, busy}), 5'b10100);

        // Directed corners
        do_op(1'b1, 5'h00, 12'h000);
        do_op(1'b1, 5'h0F, 12'hFFF);
        do_op(1'b1, 5'h05, 12'hAAA);
        do_op(1'b1, 5'h0A, 12'h555);
        do_op(1'b0, 5'h00, 12'h000);
        do_op(1'b0, 5'h1F, 12'h000);
        do_op(1'b0, 5'h15, 12'h000);

        // R8: requests while busy are not taken
        ef0 = en_falls;
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 5'h3; req_wdata = 12'h123;
        @(negedge clk);
        req_write = 1'b0; req_addr = 5'h1E;
        repeat (5) begin
            @(negedge clk);
            check(busy && !req_ack, "R8 no ack while busy", int'(req_ack), 0);
        end
        req_valid = 1'b0;
        while (busy) @(negedge clk);
        repeat (6 * HD) @(negedge clk);
        check(en_falls == ef0 + 1, "R8 single frame", en_falls - ef0, 1);
        check(got_wframe == 16'h1233, "R8 first request kept", int'(got_wframe), 16'h1233);

        // Random mix
        for (int i = 0; i < 40; i++) begin
            logic [4:0]  a = 5'($urandom);
            logic [11:0] d = 12'($urandom);
            bit          w = 1'($urandom);
            do_op(w, a, d);
        end

        check(min_hold >= HD, "R10 clock level hold", min_hold, HD);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule